// File: doc/BRIEF.md
# Two-wire bus slave address front end

This block sits between the SDA/SCL pins of a two-wire serial bus and the data phase logic of a serial memory slave. Both bus lines are oversampled by a faster system clock through a short synchronizer. The block watches for start and stop conditions and shifts in the first byte after a start, most significant bit first. It compares the upper bits of that byte with a fixed device family code and the next three bits with three strap inputs. When the byte matches, the block drives the acknowledge on the ninth SCL pulse and tells downstream logic whether a read or a write follows.

SDA is treated as open drain: the block only ever pulls the line low through an output enable. A standby indication reports when the slave is quiescent. It is high after reset. It drops while a transfer is running. A stop that closes a read, a rejected address or an aborted transfer raises it again. A stop that closes a write leaves it low until the internal write reports completion on a one-cycle pulse.

Top module: `twi_addr_frontend`

## Requirements
- R1: A falling SDA while SCL is high is a start condition; it begins address reception and raises `busy`.
- R2: Before the first start, no SCL or SDA activity changes any output; `busy` stays low and `addr_hit` never pulses.
- R3: A rising SDA while SCL is high is a stop condition; it ends any transfer and `busy` falls.
- R4: The address byte is taken on SCL rising edges, most significant bit first. Bits 7..4 must be 4'b1010 and bits 3..1 must equal `strap_sel[2:0]`, with strap bit 2 at byte bit 3. On a match `addr_hit` pulses for one clock and `rd_nwr` takes bit 0 (1 = read, 0 = write) and holds it until the next match.
- R5: After a matching byte, `sda_oe` goes high after the SCL fall that ends the eighth bit and stays high through the whole ninth SCL pulse. It is released after the ninth SCL fall.
- R6: On a non-matching byte there is no acknowledge and no `addr_hit`, `busy` falls, and the bus is ignored until the next start.
- R7: A start at any point, including mid-byte, clears the bit count and restarts address reception from the first bit.
- R8: `standby` is high after reset and falls on every start.
- R9: A stop that ends anything other than an acknowledged write raises `standby`, provided no internal write is pending.
- R10: A stop after an acknowledged write leaves `standby` low until `wr_done` pulses while the bus is idle. A `wr_done` pulse while no write is pending has no effect.
- R11: Each output reacts on the third rising `clk` edge after the bus pin change that causes it (two synchronizer stages plus one detection register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level (wired bus value) |
| strap_sel | input | 3 | Device select strap levels |
| wr_done | input | 1 | One-cycle pulse when the internal write completes |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| addr_hit | output | 1 | One-cycle pulse on a matching address byte |
| rd_nwr | output | 1 | Operation of the last match, 1 = read |
| busy | output | 1 | A transfer is being received or served |
| standby | output | 1 | Slave is quiescent |

## Verification
The hardest state to reach is a pending internal write that overlaps other bus traffic. An acknowledged write must be closed by a stop. A second transfer then runs while `wr_done` has not yet arrived, and `standby` must stay low through that transfer's stop. The bench builds this sequence from start, byte, acknowledge and stop tasks. It places `wr_done` pulses both in the idle gap and inside an unrelated read. A mid-byte repeated start is made by raising SCL with SDA high and then pulling SDA low. The reference model follows the same pins through its own three-sample history.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_ACKWAIT = 3'd2,
    ST_ACK     = 3'd3,
    ST_PHASE   = 3'd4
  } twi_state_e;

  localparam logic [3:0] TWI_FAMILY_DEFAULT = 4'b1010;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= {WIDTH{RST_VAL}};
          else     chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= {WIDTH{RST_VAL}};
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl
);

  logic scl_p;
  logic sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // SDA edges while SCL held high are conditions, never data
  assign start_ev = scl_p & scl_s &  sda_p & ~sda_s;
  assign stop_ev  = scl_p & scl_s & ~sda_p &  sda_s;
  assign scl_rise = ~scl_p &  scl_s;
  assign scl_fall =  scl_p & ~scl_s;
  assign sda_lvl  = sda_s;

endmodule

// File: rtl/twi_addr_fsm.sv
module twi_addr_fsm
  import twi_pkg::*;
#(
  parameter int               ADDR_BITS = 8,
  parameter int               STRAP_W   = 3,
  parameter logic [3:0]       FAMILY    = TWI_FAMILY_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_lvl,
  input  logic [STRAP_W-1:0] strap_sel,
  output logic               sda_oe,
  output logic               addr_hit,
  output logic               rd_nwr,
  output logic               busy,
  output logic               end_write
);

  localparam int FAM_W = ADDR_BITS - 1 - STRAP_W;
  localparam int CNT_W = $clog2(ADDR_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_BITS - 1);

  twi_state_e             state_q, state_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [ADDR_BITS-2:0]   sh_q, sh_d;
  logic [ADDR_BITS-1:0]   full_byte;
  logic                   match;
  logic                   oe_d, hit_d, rw_d;

  assign full_byte = {sh_q, sda_lvl};
  assign match = (full_byte[ADDR_BITS-1 -: FAM_W] == FAMILY[FAM_W-1:0]) &&
                 (full_byte[STRAP_W:1] == strap_sel);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    oe_d    = sda_oe;
    hit_d   = 1'b0;
    rw_d    = rd_nwr;
    if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d = full_byte[ADDR_BITS-2:0];
            if (cnt_q == LAST_BIT) begin
              if (match) begin
                state_d = ST_ACKWAIT;
                hit_d   = 1'b1;
                rw_d    = sda_lvl;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_ACKWAIT: begin
          if (scl_fall) begin
            state_d = ST_ACK;
            oe_d    = 1'b1;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_d = ST_PHASE;
            oe_d    = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      sda_oe   <= 1'b0;
      addr_hit <= 1'b0;
      rd_nwr   <= 1'b0;
      busy     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      sda_oe   <= oe_d;
      addr_hit <= hit_d;
      rd_nwr   <= rw_d;
      busy     <= (state_d != ST_IDLE);
    end
  end

  assign end_write = (state_q == ST_PHASE) && !rd_nwr;

endmodule

// File: rtl/twi_standby.sv
module twi_standby (
  input  logic clk,
  input  logic rst,
  input  logic start_ev,
  input  logic stop_ev,
  input  logic end_write,
  input  logic wr_done,
  input  logic busy,
  output logic standby
);

  logic wr_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      standby   <= 1'b1;
      wr_pend_q <= 1'b0;
    end else if (start_ev) begin
      standby <= 1'b0;
      if (wr_done) wr_pend_q <= 1'b0;
    end else if (stop_ev) begin
      if (end_write)       wr_pend_q <= 1'b1;
      else if (!wr_pend_q) standby   <= 1'b1;
    end else if (wr_done && wr_pend_q) begin
      wr_pend_q <= 1'b0;
      if (!busy) standby <= 1'b1;
    end
  end

endmodule

// File: rtl/twi_addr_frontend.sv
module twi_addr_frontend
  import twi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_BITS   = 8,
  parameter int         STRAP_W     = 3,
  parameter logic [3:0] FAMILY      = TWI_FAMILY_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap_sel,
  input  logic               wr_done,
  output logic               sda_oe,
  output logic               addr_hit,
  output logic               rd_nwr,
  output logic               busy,
  output logic               standby
);

  logic [1:0] pins_s;
  logic start_ev, stop_ev, scl_rise, scl_fall, sda_lvl, end_write;

  twi_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(pins_s)
  );

  twi_cond_detect u_cond (
    .clk(clk), .rst(rst), .scl_s(pins_s[1]), .sda_s(pins_s[0]),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_lvl(sda_lvl)
  );

  twi_addr_fsm #(.ADDR_BITS(ADDR_BITS), .STRAP_W(STRAP_W), .FAMILY(FAMILY)) u_fsm (
    .clk(clk), .rst(rst), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .strap_sel(strap_sel), .sda_oe(sda_oe), .addr_hit(addr_hit),
    .rd_nwr(rd_nwr), .busy(busy), .end_write(end_write)
  );

  twi_standby u_stby (
    .clk(clk), .rst(rst), .start_ev(start_ev), .stop_ev(stop_ev),
    .end_write(end_write), .wr_done(wr_done), .busy(busy), .standby(standby)
  );

endmodule

// File: rtl/twi_addr_frontend_chk.sv
module twi_addr_frontend_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic addr_hit,
  input logic busy,
  input logic standby
);

  // R5
  ack_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> busy);

  // R4
  hit_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    addr_hit |=> !addr_hit);

  // R4
  hit_in_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> busy);

  // R8
  standby_excl_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !standby);

  // R5
  ack_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !addr_hit);

  // R9
  standby_rise_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(standby) |-> !busy);

endmodule

bind twi_addr_frontend twi_addr_frontend_chk chk_i (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .addr_hit(addr_hit),
  .busy(busy), .standby(standby)
);

// File: tb/twi_addr_frontend_tb_top.sv
`timescale 1ns/1ps
module twi_addr_frontend_tb_top;

  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wr_done = 1'b0;
  logic sda_oe, addr_hit, rd_nwr, busy, standby;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int hits = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  twi_addr_frontend dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .strap_sel(strap), .wr_done(wr_done), .sda_oe(sda_oe),
    .addr_hit(addr_hit), .rd_nwr(rd_nwr), .busy(busy), .standby(standby)
  );

  // Behavioural reference model: three-sample pin history (R11)
  bit h1s, h2s, h3s, h1d, h2d, h3d;
  int m_st, m_cnt;
  bit [7:0] m_sh;
  bit m_oe, m_hit, m_rw, m_busy, m_sb, m_wp;

  always @(posedge clk) begin
    bit st_ev, sp_ev, rise, fall, end_wr, busy_old, pin_d;
    if (rst) begin
      h1s = 1; h2s = 1; h3s = 1; h1d = 1; h2d = 1; h3d = 1;
      m_st = 0; m_cnt = 0; m_sh = 0;
      m_oe = 0; m_hit = 0; m_rw = 0; m_busy = 0; m_sb = 1; m_wp = 0;
    end else begin
      pin_d  = sda_m & ~m_oe;
      st_ev  = h3s && h2s && h3d && !h2d;
      sp_ev  = h3s && h2s && !h3d && h2d;
      rise   = !h3s && h2s;
      fall   = h3s && !h2s;
      end_wr = (m_st == 4) && !m_rw;
      busy_old = m_busy;
      m_hit  = 0;
      if (st_ev) begin
        m_st = 1; m_cnt = 0; m_oe = 0;
      end else if (sp_ev) begin
        m_st = 0; m_oe = 0;
      end else if (m_st == 1 && rise) begin
        m_sh = {m_sh[6:0], h2d};
        if (m_cnt == 7) begin
          if (m_sh[7:4] == 4'b1010 && m_sh[3:1] == strap) begin
            m_st = 2; m_hit = 1; m_rw = m_sh[0];
          end else m_st = 0;
        end else m_cnt++;
      end else if (m_st == 2 && fall) begin
        m_st = 3; m_oe = 1;
      end else if (m_st == 3 && fall) begin
        m_st = 4; m_oe = 0;
      end
      if (st_ev) begin
        m_sb = 0;
        if (wr_done) m_wp = 0;
      end else if (sp_ev) begin
        if (end_wr) m_wp = 1;
        else if (!m_wp) m_sb = 1;
      end else if (wr_done && m_wp) begin
        m_wp = 0;
        if (!busy_old) m_sb = 1;
      end
      m_busy = (m_st != 0);
      h3s = h2s; h2s = h1s; h1s = scl_m;
      h3d = h2d; h2d = h1d; h1d = pin_d;
    end
  end

  task automatic chk(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(sda_oe,   m_oe,   "R5 sda_oe vs model");
      chk(addr_hit, m_hit,  "R4 addr_hit vs model");
      chk(rd_nwr,   m_rw,   "R4 rd_nwr vs model");
      chk(busy,     m_busy, "R3 busy vs model");
      chk(standby,  m_sb,   "R9 standby vs model");
      if (addr_hit) hits++;
    end
  end

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wait_hp();
    scl_m = 1; wait_hp();
    sda_m = 0; wait_hp();
    scl_m = 0; wait_hp();
  endtask

  task automatic bus_stop();
    sda_m = 0; wait_hp();
    scl_m = 1; wait_hp();
    sda_m = 1; wait_hp();
  endtask

  task automatic bus_bit(input bit b);
    sda_m = b; wait_hp();
    scl_m = 1; wait_hp();
    scl_m = 0; wait_hp();
  endtask

  task automatic send_byte(input bit [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
  endtask

  // ninth clock with master releasing SDA
  task automatic ack_clock(input bit exp_ack, input string tag);
    sda_m = 1; wait_hp();
    chk(sda_oe, exp_ack, tag);
    scl_m = 1; wait_hp();
    chk(sda_oe, exp_ack, tag);
    chk(sda_bus, !exp_ack, tag);
    scl_m = 0; wait_hp();
    chk(sda_oe, 1'b0, tag);
  endtask

  task automatic pulse_done();
    wr_done = 1; @(negedge clk); wr_done = 0; wait_hp();
  endtask

  initial begin
    int h0;
    repeat (4) @(negedge clk);
    rst = 0;
    wait_hp();
    chk(standby, 1, "R8 standby after reset");
    chk(busy, 0, "R8 busy after reset");

    // R2: clocking without a start
    scl_m = 0; wait_hp();
    send_byte(8'hAA);
    bus_bit(1);
    chk(busy, 0, "R2 busy without start");
    chk(hits == 0, 1, "R2 no hit without start");
    scl_m = 1; wait_hp();

    // R1/R4/R5/R10: matching write
    bus_start();
    chk(busy, 1, "R1 busy after start");
    chk(standby, 0, "R8 standby falls on start");
    h0 = hits;
    send_byte({4'b1010, strap, 1'b0});
    chk(hits == h0 + 1, 1, "R4 write address hit");
    chk(rd_nwr, 0, "R4 write bit");
    ack_clock(1, "R5 acknowledge write");
    bus_stop();
    chk(busy, 0, "R3 busy after stop");
    chk(standby, 0, "R10 standby held after write stop");

    // R10: write pending across a read transfer
    bus_start();
    send_byte({4'b1010, strap, 1'b1});
    ack_clock(1, "R5 acknowledge read");
    bus_stop();
    chk(standby, 0, "R10 pending write keeps standby low");
    pulse_done();
    chk(standby, 1, "R10 standby after write done");

    // R10: stray wr_done inside a read is ignored, R9 read stop
    bus_start();
    send_byte({4'b1010, strap, 1'b1});
    chk(rd_nwr, 1, "R4 read bit");
    ack_clock(1, "R5 acknowledge read 2");
    pulse_done();
    chk(standby, 0, "R10 stray wr_done ignored");
    bus_stop();
    chk(standby, 1, "R9 standby after read stop");

    // R6: family mismatch
    bus_start();
    h0 = hits;
    send_byte({4'b1110, strap, 1'b0});
    chk(hits == h0, 1, "R6 no hit on family mismatch");
    chk(busy, 0, "R6 busy drops on mismatch");
    ack_clock(0, "R6 no acknowledge family");
    send_byte({4'b1010, strap, 1'b1});
    chk(hits == h0, 1, "R6 bus ignored after mismatch");
    bus_stop();
    chk(standby, 1, "R9 standby after rejected stop");

    // R6: strap mismatch
    bus_start();
    h0 = hits;
    send_byte({4'b1010, ~strap, 1'b1});
    chk(hits == h0, 1, "R6 no hit on strap mismatch");
    ack_clock(0, "R6 no acknowledge strap");
    bus_stop();

    // R7: restart mid-byte
    bus_start();
    h0 = hits;
    bus_bit(1); bus_bit(0); bus_bit(1); bus_bit(1);
    bus_start();
    chk(busy, 1, "R7 busy after restart");
    send_byte({4'b1010, strap, 1'b1});
    chk(hits == h0 + 1, 1, "R7 hit after restart");
    ack_clock(1, "R7 acknowledge after restart");
    bus_stop();

    // R4: other strap setting
    strap = 3'b010;
    wait_hp();
    bus_start();
    h0 = hits;
    send_byte({4'b1010, 3'b010, 1'b0});
    chk(hits == h0 + 1, 1, "R4 hit with strap 010");
    ack_clock(1, "R5 acknowledge strap 010");
    bus_stop();
    chk(standby, 0, "R10 second write pending");
    pulse_done();
    chk(standby, 1, "R10 second write done");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule